// File: doc/BRIEF.md
# Dual-Exponent Modular Power Sequencer

This block steers an external modular multiplier to form g0^e0 · g1^e1 mod m. It walks both exponents with one shared square-and-multiply loop. The multiplier holds four operand slots. Slot 0 holds g0, slot 1 holds g1 and slot 2 holds g0·g1, all in Montgomery form. Slot 3 is the accumulator and starts at R mod m. The sequencer only chooses which slots feed the multiplier and where the product goes. It pulses the multiplier's start and waits for its done.

In single mode a host start runs exactly one multiplication. The two sources and the destination come from host select inputs. In auto mode the exponent bits come from a small FIFO of packed words. For every bit position the sequencer squares the accumulator. It then multiplies the accumulator by the slot that the current (e1,e0) bit pair selects, or skips that step when both bits are zero.

A multiplication takes (pipeline stages + 2·(width − 1)) cycles, which is 96 + 2·(width − 1) at full size. An auto run costs on average 7/4 multiplications per exponent bit. The sequencer itself does not depend on that latency, because it waits on the multiplier's done.

Top module: `simexp_seq`

## Requirements
- R1: A one-cycle start_i pulse seen while idle begins an operation. ready_o goes high for exactly one cycle when that operation has completely finished. Without a start, no multiplication is issued.
- R2: With run_auto_i low at start, exactly one multiplication is issued. Its x, y and destination selects are the values of x_sel_i, y_sel_i and dest_sel_i captured in the start cycle.
- R3: With run_auto_i high at start, the block runs the auto exponentiation. On completion the accumulator slot 3 holds g0^e0 · g1^e1 mod m.
- R4: A FIFO word carries an e1 chunk in bits [31:16] and the matching e0 chunk in bits [15:0]. The first word pushed holds the most significant chunk.
- R5: Bit positions within a word are processed from bit 15 down to bit 0. Each position first issues a square (x=3, y=3, dest=3). The pair (e1,e0) then selects a multiply with x=3 and dest=3: y=0 for pair 01, y=1 for pair 10, y=2 for pair 11. Pair 00 issues no multiply.
- R6: A word is popped after its 16 pairs are done. If the FIFO is then empty, ready_o is raised. An auto start with an empty FIFO raises ready_o without any multiplication.
- R7: A start pulse that arrives while an operation is running is ignored. The sequence of multiplications and the single ready pulse are unchanged.
- R8: fifo_full_o is high when DEPTH words are held. A push while full is refused and leaves the contents unchanged. fifo_nopush_o is high during the cycle that follows the refused push, and only then.
- R9: mul_start_o is a one-cycle pulse per multiplication. It is never raised while a multiplication is still waiting for its done.
- R10: After reset, ready_o, mul_start_o, fifo_full_o and fifo_nopush_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin an operation |
| run_auto_i | input | 1 | Selects auto exponentiation when high at start |
| x_sel_i | input | 2 | Single mode first source slot |
| y_sel_i | input | 2 | Single mode second source slot |
| dest_sel_i | input | 2 | Single mode destination slot |
| fifo_din_i | input | 32 | Packed exponent word {e1 chunk, e0 chunk} |
| fifo_push_i | input | 1 | Push fifo_din_i into the exponent FIFO |
| fifo_full_o | output | 1 | Exponent FIFO holds DEPTH words |
| fifo_nopush_o | output | 1 | Previous cycle's push was refused |
| mul_start_o | output | 1 | Start pulse to the multiplier |
| mul_x_o | output | 2 | Multiplier first source slot |
| mul_y_o | output | 2 | Multiplier second source slot |
| mul_dest_o | output | 2 | Multiplier destination slot |
| mul_done_i | input | 1 | Multiplier finished the current product |
| ready_o | output | 1 | One-cycle pulse when the operation finished |

## Verification
The bench models the multiplier with plain modular products over four slots and logs every issued (x, y, dest) triple. Each auto run is checked two ways: the log must match the per-bit expectation, and the final accumulator must equal a separately computed g0^e0·g1^e1. The exponent patterns each isolate one behaviour. A mixed single word exercises all four pair codes. All-zero words confirm that multiplies are skipped. An e1-free pair of words confirms that only slot 0 is used and that the word order is right. A full FIFO with a refused extra word shows that the refused word never reaches the exponent. A run with a start pulse injected part-way, and an auto start with an empty FIFO, cover the ignored-start and empty cases.

// File: rtl/simexp_pkg.sv
package simexp_pkg;
  typedef logic [1:0] slot_t;
  localparam slot_t SLOT_G0  = 2'd0;
  localparam slot_t SLOT_G1  = 2'd1;
  localparam slot_t SLOT_G01 = 2'd2;
  localparam slot_t SLOT_ACC = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ONE_GO,
    ST_ONE_WAIT,
    ST_SQ_GO,
    ST_SQ_WAIT,
    ST_ML_GO,
    ST_ML_WAIT,
    ST_NEXT,
    ST_CHECK,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/simexp_fifo.sv
module simexp_fifo #(
  parameter int DEPTH  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] din_i,
  input  logic              push_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              nopush_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              nopush_q;
  logic              do_push, do_pop;

  assign full_o   = (cnt_q == CNT_W'(DEPTH));
  assign empty_o  = (cnt_q == '0);
  assign do_push  = push_i && !full_o;
  assign do_pop   = pop_i && !empty_o;
  assign head_o   = mem_q[rd_q];
  assign nopush_o = nopush_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q     <= '0;
      rd_q     <= '0;
      cnt_q    <= '0;
      nopush_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      nopush_q <= push_i && full_o;
      if (do_push) begin
        mem_q[wr_q] <= din_i;
        wr_q        <= ptr_inc(wr_q);
      end
      if (do_pop) rd_q <= ptr_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_pop_nonempty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_refuse_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |=> nopush_o);
  p_refuse_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/simexp_pair_pick.sv
module simexp_pair_pick
  import simexp_pkg::*;
#(
  parameter int CHUNK_W = 16,
  localparam int IDX_W  = $clog2(CHUNK_W),
  localparam int WORD_W = 2 * CHUNK_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  idx_i,
  output slot_t             y_sel_o,
  output logic              need_mul_o
);
  logic [1:0] pair;
  assign pair = {word_i[CHUNK_W + 32'(idx_i)], word_i[32'(idx_i)]};

  always_comb begin
    need_mul_o = 1'b1;
    unique case (pair)
      2'b01:   y_sel_o = SLOT_G0;
      2'b10:   y_sel_o = SLOT_G1;
      2'b11:   y_sel_o = SLOT_G01;
      default: begin
        y_sel_o    = SLOT_G0;
        need_mul_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/simexp_ctrl.sv
module simexp_ctrl
  import simexp_pkg::*;
#(
  parameter int CHUNK_W = 16,
  localparam int IDX_W  = $clog2(CHUNK_W),
  localparam int WORD_W = 2 * CHUNK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              run_auto_i,
  input  slot_t             x_sel_i,
  input  slot_t             y_sel_i,
  input  slot_t             dest_sel_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              empty_i,
  output logic              pop_o,
  input  logic              mul_done_i,
  output logic              mul_start_o,
  output slot_t             mul_x_o,
  output slot_t             mul_y_o,
  output slot_t             mul_dest_o,
  output logic              ready_o
);
  seq_state_e       state_q;
  logic             auto_q;
  slot_t            xs_q, ys_q, ds_q;
  logic [IDX_W-1:0] idx_q;
  slot_t            pick_y;
  logic             need_mul;

  simexp_pair_pick #(.CHUNK_W(CHUNK_W)) u_pick (
    .word_i    (word_i),
    .idx_i     (idx_q),
    .y_sel_o   (pick_y),
    .need_mul_o(need_mul)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      auto_q  <= 1'b0;
      xs_q    <= SLOT_G0;
      ys_q    <= SLOT_G0;
      ds_q    <= SLOT_G0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          auto_q <= run_auto_i;
          xs_q   <= x_sel_i;
          ys_q   <= y_sel_i;
          ds_q   <= dest_sel_i;
          idx_q  <= IDX_W'(CHUNK_W - 1);
          if (!run_auto_i)  state_q <= ST_ONE_GO;
          else if (empty_i) state_q <= ST_DONE;
          else              state_q <= ST_SQ_GO;
        end
        ST_ONE_GO:   state_q <= ST_ONE_WAIT;
        ST_ONE_WAIT: if (mul_done_i) state_q <= ST_DONE;
        ST_SQ_GO:    state_q <= ST_SQ_WAIT;
        ST_SQ_WAIT:  if (mul_done_i) state_q <= need_mul ? ST_ML_GO : ST_NEXT;
        ST_ML_GO:    state_q <= ST_ML_WAIT;
        ST_ML_WAIT:  if (mul_done_i) state_q <= ST_NEXT;
        ST_NEXT: begin
          if (idx_q == '0) state_q <= ST_CHECK;
          else begin
            idx_q   <= idx_q - 1'b1;
            state_q <= ST_SQ_GO;
          end
        end
        ST_CHECK: begin
          idx_q   <= IDX_W'(CHUNK_W - 1);
          state_q <= empty_i ? ST_DONE : ST_SQ_GO;
        end
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mul_start_o = 1'b0;
    mul_x_o     = SLOT_G0;
    mul_y_o     = SLOT_G0;
    mul_dest_o  = SLOT_G0;
    unique case (state_q)
      ST_ONE_GO, ST_ONE_WAIT: begin
        mul_start_o = (state_q == ST_ONE_GO);
        mul_x_o     = xs_q;
        mul_y_o     = ys_q;
        mul_dest_o  = ds_q;
      end
      ST_SQ_GO, ST_SQ_WAIT: begin
        mul_start_o = (state_q == ST_SQ_GO);
        mul_x_o     = SLOT_ACC;
        mul_y_o     = SLOT_ACC;
        mul_dest_o  = SLOT_ACC;
      end
      ST_ML_GO, ST_ML_WAIT: begin
        mul_start_o = (state_q == ST_ML_GO);
        mul_x_o     = SLOT_ACC;
        mul_y_o     = pick_y;
        mul_dest_o  = SLOT_ACC;
      end
      default: ;
    endcase
  end

  assign pop_o   = (state_q == ST_NEXT) && (idx_q == '0);
  assign ready_o = (state_q == ST_DONE);

  p_start_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_start_o |=> !mul_start_o);
  p_ready_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  p_auto_dest_acc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mul_start_o && auto_q) |-> (mul_dest_o == SLOT_ACC));
  p_mul_needs_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ML_GO) |-> need_mul);
  p_no_start_waiting_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mul_start_o && !mul_done_i) |=> !mul_start_o);
endmodule

// File: rtl/simexp_seq.sv
module simexp_seq
  import simexp_pkg::*;
#(
  parameter int CHUNK_W = 16,
  parameter int DEPTH   = 4,
  localparam int WORD_W = 2 * CHUNK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              run_auto_i,
  input  logic [1:0]        x_sel_i,
  input  logic [1:0]        y_sel_i,
  input  logic [1:0]        dest_sel_i,
  input  logic [WORD_W-1:0] fifo_din_i,
  input  logic              fifo_push_i,
  output logic              fifo_full_o,
  output logic              fifo_nopush_o,
  output logic              mul_start_o,
  output logic [1:0]        mul_x_o,
  output logic [1:0]        mul_y_o,
  output logic [1:0]        mul_dest_o,
  input  logic              mul_done_i,
  output logic              ready_o
);
  logic [WORD_W-1:0] head;
  logic              empty, pop;

  simexp_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .din_i   (fifo_din_i),
    .push_i  (fifo_push_i),
    .pop_i   (pop),
    .head_o  (head),
    .empty_o (empty),
    .full_o  (fifo_full_o),
    .nopush_o(fifo_nopush_o)
  );

  simexp_ctrl #(.CHUNK_W(CHUNK_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .run_auto_i (run_auto_i),
    .x_sel_i    (x_sel_i),
    .y_sel_i    (y_sel_i),
    .dest_sel_i (dest_sel_i),
    .word_i     (head),
    .empty_i    (empty),
    .pop_o      (pop),
    .mul_done_i (mul_done_i),
    .mul_start_o(mul_start_o),
    .mul_x_o    (mul_x_o),
    .mul_y_o    (mul_y_o),
    .mul_dest_o (mul_dest_o),
    .ready_o    (ready_o)
  );

  p_ready_ends_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mul_start_o);
endmodule

// File: tb/simexp_seq_test.sv
module simexp_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 4;
  localparam int DEPTH      = 4;
  localparam longint unsigned MODV = 64'd1000003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, run_auto = 1'b0;
  logic [1:0]  xs = '0, ys = '0, ds = '0;
  logic [31:0] din = '0;
  logic        push = 1'b0;
  logic        full, nopush, mul_start, ready;
  logic [1:0]  mx, my, md;
  logic        mul_done;

  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  simexp_seq #(.CHUNK_W(16), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .run_auto_i(run_auto),
    .x_sel_i(xs), .y_sel_i(ys), .dest_sel_i(ds),
    .fifo_din_i(din), .fifo_push_i(push),
    .fifo_full_o(full), .fifo_nopush_o(nopush),
    .mul_start_o(mul_start), .mul_x_o(mx), .mul_y_o(my), .mul_dest_o(md),
    .mul_done_i(mul_done), .ready_o(ready)
  );

  // multiplier stand-in: plain modular product, fixed latency, logs each request
  logic [63:0] ops [4];
  logic [63:0] seed_v [4];
  logic        seed = 1'b0;
  int          cnt, log_n, busy_err;
  logic [5:0]  log_e [256];
  logic [1:0]  sx, sy, sd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= 0; mul_done <= 1'b0; log_n <= 0; busy_err <= 0;
      sx <= '0; sy <= '0; sd <= '0;
    end else begin
      mul_done <= 1'b0;
      if (seed) begin
        for (int k = 0; k < 4; k++) ops[k] <= seed_v[k];
        log_n <= 0;
      end
      if (cnt != 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) begin
          mul_done <= 1'b1;
          ops[sd]  <= (ops[sx] * ops[sy]) % MODV;
        end
        if (mul_start) busy_err <= busy_err + 1;
      end else if (mul_start) begin
        cnt <= LAT; sx <= mx; sy <= my; sd <= md;
        log_e[log_n[7:0]] <= {mx, my, md};
        log_n <= log_n + 1;
      end
    end
  end

  int ready_cnt;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ready_cnt <= 0;
    else if (ready) ready_cnt <= ready_cnt + 1;

  logic [31:0] wq [8];
  int          wn;
  logic [5:0]  exp_e [256];
  int          exp_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic longint unsigned powm(input longint unsigned b, input longint unsigned e);
    longint unsigned r = 1, bb = b % MODV, ee = e;
    for (int i = 0; i < 64; i++) begin
      if (ee[0]) r = (r * bb) % MODV;
      bb = (bb * bb) % MODV;
      ee = ee >> 1;
    end
    return r;
  endfunction

  task automatic seed_ops(input longint unsigned g0, input longint unsigned g1);
    @(negedge clk);
    seed_v[0] = g0; seed_v[1] = g1; seed_v[2] = (g0 * g1) % MODV; seed_v[3] = 1;
    seed = 1'b1;
    @(negedge clk);
    seed = 1'b0;
  endtask

  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    din = w; push = 1'b1;
    @(negedge clk);
    push = 1'b0;
  endtask

  task automatic pulse_start(input bit autom, input logic [1:0] x, input logic [1:0] y,
                             input logic [1:0] d);
    @(negedge clk);
    run_auto = autom; xs = x; ys = y; ds = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0; run_auto = 1'b0;
  endtask

  task automatic wait_ready(input int base, input string req);
    int t = 0;
    while (ready_cnt == base && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(ready_cnt != base, req, "ready timeout", t, 20000);
    repeat (LAT + 6) @(negedge clk);
  endtask

  // auto run over wq[0..wn-1]; optional start injected part-way (R7)
  task automatic auto_run(input string name, input longint unsigned g0,
                          input longint unsigned g1, input bit inject, input bit push_words);
    longint unsigned e0 = 0, e1 = 0, want;
    int base, bad;
    seed_ops(g0, g1);
    if (push_words) for (int i = 0; i < wn; i++) push_word(wq[i]);
    exp_n = 0;
    for (int i = 0; i < wn; i++) begin
      e1 = (e1 << 16) | longint'(wq[i][31:16]);
      e0 = (e0 << 16) | longint'(wq[i][15:0]);
      for (int b = 15; b >= 0; b--) begin
        exp_e[exp_n] = 6'b11_11_11; exp_n++;
        case ({wq[i][16 + b], wq[i][b]})
          2'b01: begin exp_e[exp_n] = 6'b11_00_11; exp_n++; end
          2'b10: begin exp_e[exp_n] = 6'b11_01_11; exp_n++; end
          2'b11: begin exp_e[exp_n] = 6'b11_10_11; exp_n++; end
          default: ;
        endcase
      end
    end
    want = (powm(g0, e0) * powm(g1, e1)) % MODV;
    base = ready_cnt;
    pulse_start(1'b1, 2'd0, 2'd0, 2'd0);
    if (inject) begin
      repeat (20) @(negedge clk);
      pulse_start(1'b0, 2'd0, 2'd1, 2'd2);
    end
    wait_ready(base, "R1");
    chk(ready_cnt - base == 1, "R1", {name, " ready pulses"}, ready_cnt - base, 1);
    chk(log_n == exp_n, inject ? "R7" : "R5", {name, " mult count"}, log_n, exp_n);
    bad = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (bad < 0 && log_e[i] != exp_e[i]) bad = i;
    chk(bad < 0, inject ? "R7" : "R5", {name, " select sequence, first bad index"}, bad, -1);
    chk(ops[3] == want, "R3", {name, " accumulator (R4 order)"}, longint'(ops[3]), longint'(want));
    chk(busy_err == 0, "R9", {name, " start while busy"}, busy_err, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!ready && !mul_start, "R10", "ready/mul_start after reset", {ready, mul_start}, 0);
    chk(!full && !nopush, "R10", "fifo flags after reset", {full, nopush}, 0);
    repeat (5) @(negedge clk);
    chk(log_n == 0, "R1", "no mult without start", log_n, 0);
  endtask

  task automatic t_single;
    int base;
    seed_ops(5, 7);
    base = ready_cnt;
    pulse_start(1'b0, 2'd1, 2'd2, 2'd0);
    wait_ready(base, "R2");
    chk(log_n == 1, "R2", "single mult count", log_n, 1);
    chk(log_e[0] == {2'd1, 2'd2, 2'd0}, "R2", "single selects", log_e[0], {2'd1, 2'd2, 2'd0});
    chk(ops[0] == 245, "R2", "single product slot0", longint'(ops[0]), 245);
    chk(ready_cnt - base == 1, "R1", "single ready pulses", ready_cnt - base, 1);
    base = ready_cnt;
    pulse_start(1'b0, 2'd3, 2'd0, 2'd2);
    wait_ready(base, "R2");
    chk(log_n == 2 && log_e[1] == {2'd3, 2'd0, 2'd2}, "R2", "second single selects",
        log_e[1], {2'd3, 2'd0, 2'd2});
    chk(ops[2] == 245, "R2", "second single product slot2", longint'(ops[2]), 245);
  endtask

  task automatic t_empty;
    int base;
    seed_ops(3, 4);
    base = ready_cnt;
    pulse_start(1'b1, 2'd0, 2'd0, 2'd0);
    repeat (3) @(negedge clk);
    chk(ready_cnt - base == 1, "R6", "empty fifo ready", ready_cnt - base, 1);
    chk(log_n == 0, "R6", "empty fifo no mult", log_n, 0);
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH; i++) wq[i] = 32'h1234_0000 + 32'(i * 16'h0f0f + 3);
    wn = DEPTH;
    for (int i = 0; i < DEPTH; i++) push_word(wq[i]);
    chk(full, "R8", "full after DEPTH pushes", full, 1);
    chk(!nopush, "R8", "nopush idle", nopush, 0);
    @(negedge clk);
    din = 32'hFFFF_FFFF; push = 1'b1;
    @(negedge clk);
    push = 1'b0;
    chk(nopush, "R8", "nopush after refused push", nopush, 1);
    @(negedge clk);
    chk(!nopush, "R8", "nopush one cycle only", nopush, 0);
    auto_run("full", 11, 13, 1'b0, 1'b0);
    chk(!full, "R8", "full clear after drain", full, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_empty();
    wq[0] = 32'hA5C3_3C5A; wn = 1;
    auto_run("mixed", 123, 456, 1'b0, 1'b1);
    wq[0] = 32'h0; wq[1] = 32'h0; wn = 2;
    auto_run("zero", 77, 88, 1'b0, 1'b1);
    wq[0] = 32'h0000_FFFF; wq[1] = 32'h0000_0001; wn = 2;
    auto_run("e0only", 9, 10, 1'b0, 1'b1);
    wq[0] = 32'h8001_0001; wn = 1;
    auto_run("inject", 21, 31, 1'b1, 1'b1);
    t_full();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule